// File: doc/BRIEF.md
# Time-Redundant Transient-Filtering Register

This block is a pipeline register stage that tolerates brief disturbances. Each data bit is sampled twice: once at the main clock edge and once at a slightly later instant. Two pulses that end before the later sample would otherwise be stored as wrong data. The later instant comes either from a second clock input that is a delayed copy of the main clock, or, as an option set at build time, from the next main clock edge. The two samples feed a per-bit hold-on-disagree element. It copies a bit to the output only when both samples of that bit agree, and otherwise keeps the value it had. A registered flag reports any sample pair that disagrees.

The delay between the two samples sets the widest pulse the stage can catch. The same delay is what the stage costs in timing. When the flag rises, the output has kept its previous value, so the surrounding logic can repeat the operation. The flag can also be counted as an upset event.

Top module: `glitch_guard_reg`

## Requirements
- R1: A synchronous active-high reset clears the output bus to all zeros and the error flag to 0.
- R2: With the delayed-clock option (LATE_SRC = LATE_CLOCK), a value that is stable at both the main edge and the delayed edge appears on the output after the next main clock edge, one cycle after capture.
- R3: Every output bit whose two samples agree takes the sampled value. Every output bit whose two samples disagree keeps its previous output value. This is decided independently for each bit.
- R4: The error flag is 1 in the cycle after a sample pair in which at least one bit differs, and 0 in the cycle after a pair in which all bits agree.
- R5: The error flag is registered and lasts one cycle for each disagreeing pair. It drops in the cycle after an agreeing pair that follows a disagreeing one.
- R6: With the cycle-based option (LATE_SRC = LATE_CYCLE), the second sample is the input at the next main clock edge. A value held for only one cycle leaves the output unchanged and raises the flag for two cycles. A value held for two cycles reaches the output.
- R7: The reset value is restored by reset at any time. It holds while reset is high, even if the two samples disagree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; primary sample, output and flag registers |
| clk_late | input | 1 | Delayed copy of clk for the second sample; unused with the cycle-based option |
| rst | input | 1 | Synchronous active-high reset |
| d_in | input | WIDTH | Data to be registered |
| q_out | output | WIDTH | Filtered registered data |
| err_out | output | 1 | Registered flag: previous sample pair disagreed |

## Verification
The bench drives the data input between the main edge and the delayed edge, so each pair has a known disagreement pattern. The patterns include a single bit, a whole nibble and every bit. A design that let disagreeing bits follow either sample would show a wrong output. A design that decided agreement for the whole word would hold or update bits that are correct. Agreeing pairs placed right after disagreeing ones expose a flag that sticks or that is not registered. In the cycle-based variant, a one-cycle pulse and a two-cycle pulse separate a correct filter from one that passes short pulses or blocks real changes. A reset applied in mid-stream checks that held state is cleared.

// File: rtl/ggr_pkg.sv
`timescale 1ns/1ps
package ggr_pkg;
   // Where the second (late) sample is taken
   typedef enum logic {
      LATE_CLOCK = 1'b0, // posedge of the separate delayed clock input
      LATE_CYCLE = 1'b1  // next posedge of the main clock
   } late_src_e;
endpackage

// File: rtl/ggr_sampler.sv
`timescale 1ns/1ps
// Produces the two time-separated samples of the input bus.
module ggr_sampler #(
   parameter int               WIDTH    = 8,
   parameter ggr_pkg::late_src_e LATE_SRC = ggr_pkg::LATE_CLOCK
) (
   input  logic             clk,
   input  logic             clk_late,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] samp_a,
   output logic [WIDTH-1:0] samp_b
);
   generate
      if (LATE_SRC == ggr_pkg::LATE_CLOCK) begin : g_late_clock
         always_ff @(posedge clk) begin
            if (rst) samp_a <= '0;
            else     samp_a <= d;
         end
         always_ff @(posedge clk_late) begin
            if (rst) samp_b <= '0;
            else     samp_b <= d;
         end
      end else begin : g_late_cycle
         logic unused_late_clk;
         assign unused_late_clk = clk_late;
         // samp_a: newest sample; samp_b: the one taken a cycle earlier
         always_ff @(posedge clk) begin
            if (rst) begin
               samp_a <= '0;
               samp_b <= '0;
            end else begin
               samp_a <= d;
               samp_b <= samp_a;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ggr_celem.sv
`timescale 1ns/1ps
// Bitwise hold-on-disagree storage element, synchronous reset to zero.
module ggr_celem #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   output logic [WIDTH-1:0] q
);
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic state;
         always_ff @(posedge clk) begin
            if (rst)                  state <= 1'b0;
            else if (in_a[i] == in_b[i]) state <= in_a[i];
         end
         assign q[i] = state;
      end
   endgenerate
endmodule

// File: rtl/ggr_mismatch.sv
`timescale 1ns/1ps
// Registered disagreement flag.
module ggr_mismatch #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   output logic             flag
);
   logic [WIDTH-1:0] diff;
   assign diff = in_a ^ in_b;
   always_ff @(posedge clk) begin
      if (rst) flag <= 1'b0;
      else     flag <= |diff;
   end
endmodule

// File: rtl/glitch_guard_reg.sv
`timescale 1ns/1ps
module glitch_guard_reg #(
   parameter int                 WIDTH    = 8,
   parameter ggr_pkg::late_src_e LATE_SRC = ggr_pkg::LATE_CLOCK
) (
   input  logic             clk,
   input  logic             clk_late,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out,
   output logic             err_out
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("glitch_guard_reg: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] smp_a;
   logic [WIDTH-1:0] smp_b;

   ggr_sampler #(.WIDTH(WIDTH), .LATE_SRC(LATE_SRC)) u_smp (
      .clk(clk), .clk_late(clk_late), .rst(rst), .d(d_in),
      .samp_a(smp_a), .samp_b(smp_b));

   ggr_celem #(.WIDTH(WIDTH)) u_cel (
      .clk(clk), .rst(rst), .in_a(smp_a), .in_b(smp_b), .q(q_out));

   ggr_mismatch #(.WIDTH(WIDTH)) u_cmp (
      .clk(clk), .rst(rst), .in_a(smp_a), .in_b(smp_b), .flag(err_out));
endmodule

// File: rtl/ggr_checker.sv
`timescale 1ns/1ps
module ggr_checker #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic [WIDTH-1:0] q,
   input logic             err
);
   assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (q == '0 && !err));

   assert_agree_loads_R3: assert property (@(posedge clk) disable iff (rst)
      (a == b) |=> (q == $past(a)));

   assert_disagree_holds_R3: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (((q ^ $past(q)) & $past(a ^ b)) == '0));

   assert_flag_set_R4: assert property (@(posedge clk) disable iff (rst)
      (a != b) |=> err);

   assert_flag_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (a == b) |=> !err);
endmodule

bind glitch_guard_reg ggr_checker #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst(rst), .a(smp_a), .b(smp_b), .q(q_out), .err(err_out));

// File: tb/sim_glitch_guard_reg.sv
`timescale 1ns/1ps
module sim_glitch_guard_reg;
   localparam int W = 8;
   localparam int N = 10;
   // {sample at main edge, sample at late edge, expected q, expected err}
   localparam logic [31:0] VEC [N] = '{
      {8'hA5, 8'hA5, 8'hA5, 8'h00},
      {8'h3C, 8'h3C, 8'h3C, 8'h00},
      {8'hFF, 8'h0F, 8'h3F, 8'h01},
      {8'h00, 8'h00, 8'h00, 8'h00},
      {8'hF0, 8'h0F, 8'h00, 8'h01},
      {8'hFF, 8'hFF, 8'hFF, 8'h00},
      {8'h00, 8'hFF, 8'hFF, 8'h01},
      {8'h5A, 8'h5A, 8'h5A, 8'h00},
      {8'h81, 8'h80, 8'h80, 8'h01},
      {8'h7E, 8'h7E, 8'h7E, 8'h00}
   };

   logic clk = 1'b0;
   logic clk_late = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] d0 = '0, d1 = '0;
   logic [W-1:0] q0, q1;
   logic e0, e1;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;
   always @(clk) begin #1; clk_late = clk; end

   glitch_guard_reg #(.WIDTH(W), .LATE_SRC(ggr_pkg::LATE_CLOCK)) u0 (
      .clk(clk), .clk_late(clk_late), .rst(rst), .d_in(d0), .q_out(q0), .err_out(e0));
   glitch_guard_reg #(.WIDTH(W), .LATE_SRC(ggr_pkg::LATE_CYCLE)) u1 (
      .clk(clk), .clk_late(clk_late), .rst(rst), .d_in(d1), .q_out(q1), .err_out(e1));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   initial begin
      #1ms;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int errcnt, badq;
      bit saw;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: state after reset
      chk("R1 q0 reset", q0, 0);
      chk("R1 err0 reset", e0, 0);
      chk("R1 q1 reset", q1, 0);

      // Table walk on u0 (R2 R3 R4 R5): a at main edge, b from +0.5 ns
      for (int i = 0; i <= N; i++) begin
         if (i < N) d0 = VEC[i][31:24];
         @(posedge clk); #0.5;
         if (i < N) d0 = VEC[i][23:16];
         @(negedge clk);
         if (i > 0) begin
            chk($sformatf("R2/R3 q vec%0d", i-1), q0, VEC[i-1][15:8]);
            chk($sformatf("R4/R5 err vec%0d", i-1), e0, VEC[i-1][0]);
         end
      end

      // R2: steady value, then R7 mid-stream reset with disagreeing samples
      d0 = 8'hC3;
      repeat (2) @(negedge clk);
      chk("R2 steady C3", q0, 8'hC3);
      rst = 1'b1;
      @(posedge clk); #0.5 d0 = 8'h3C;
      @(negedge clk);
      @(negedge clk);
      chk("R7 q0 under reset", q0, 0);
      chk("R7 err0 under reset", e0, 0);
      rst = 1'b0;
      d0 = 8'h00;

      // R6: cycle-based variant
      d1 = 8'h55;
      repeat (4) @(negedge clk);
      chk("R6 steady 55", q1, 8'h55);
      chk("R6 no err steady", e1, 0);
      // one-cycle pulse
      d1 = 8'hAA;
      @(negedge clk);
      d1 = 8'h55;
      errcnt = 0; badq = 0;
      repeat (5) begin
         @(negedge clk);
         if (e1) errcnt++;
         if (q1 !== 8'h55) badq++;
      end
      chk("R6 pulse q unchanged", badq, 0);
      chk("R6 pulse err cycles", errcnt, 2);
      // two-cycle value
      d1 = 8'hAA;
      errcnt = 0; saw = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (e1) errcnt++;
         if (q1 === 8'hAA) saw = 1;
         if (k == 1) d1 = 8'h55;
      end
      chk("R6 two-cycle value passes", saw, 1);
      chk("R6 two-cycle err cycles", errcnt, 2);
      chk("R6 settles to 55", q1, 8'h55);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule